// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload Timer with Serial Baud Select

This peripheral holds a 16-bit counter that a processor sets up and reads through a byte-wide register bus. It has a control byte, a two-bit mode byte, two counter bytes and two bytes that serve as the capture register or the reload value, depending on the mode. The counter advances on a divided system tick or on falling edges of an external count pin. A second pin, the strobe, can latch the counter into the capture bytes or force a reload.

In baud mode the counter reloads on every rollover. The overflow flag stays quiet and the strobe pin is ignored. The rollover pulses can then clock a serial port. Two select outputs tell that port whether its receive path, its transmit path or both should take these pulses instead of another timer's. An up/down variant of the reload mode takes its counting direction from the strobe pin level. The interrupt request combines the overflow flag with the external flag. The external flag is masked while up/down counting is on.

Top module: `cr_timer16`

## Requirements
- R1: After reset the control byte, mode byte, counter, capture/reload value, `irq`, `ovf_pulse`, `rx_clk_sel`, `tx_clk_sel` and `clk_out_en` are all zero.
- R2: Address map: 0 is control, 1 is mode, 2 and 3 are counter low and high, 4 and 5 are capture/reload low and high. Mode bits 7..2 and the unused addresses 6 and 7 read as zero.
- R3: Control bit 2 runs the counter. With control bit 1 at 0, it counts one system tick every 12 clocks, or every 6 clocks when `fast_mode` is 1. With control bit 1 at 1, it counts falling edges of `cnt_pin`. Both pins pass through a two-flop synchronizer. With bit 2 at 0 the counter holds.
- R4: Capture mode (control bit 0 = 1, no baud select). A strobe falling edge with control bit 3 set copies the counter into bytes 4/5 and sets the external flag (control bit 6). The counter wraps from FFFFh to 0000h and sets the overflow flag (control bit 7).
- R5: Reload mode (control bit 0 = 0, mode bit 0 = 0). A rollover from FFFFh loads the reload value and sets bit 7. A strobe falling edge with bit 3 set also loads the reload value and sets bit 6.
- R6: With control bit 3 clear, strobe edges change neither the capture value nor any flag.
- R7: Baud mode (control bit 5 or 4 set). Bit 0 is ignored and each rollover loads the reload value. Bit 7 is never set. Strobe edges neither capture nor reload nor set bit 6.
- R8: Up/down mode (mode bit 0 = 1 in reload mode). A high strobe level counts up, with the rollover from FFFFh loading the reload value. A low level counts down. Stepping down while the counter equals the reload value loads FFFFh. Each such event sets bit 7 and toggles bit 6.
- R9: `irq` is bit 7 OR (bit 6 AND NOT mode bit 0).
- R10: Only hardware sets flags, and software clears them. A control write in the same cycle as a hardware flag event wins. A counter-byte write in the same cycle as a count step wins, and the other byte keeps its value.
- R11: `rx_clk_sel` follows control bit 5, `tx_clk_sel` follows bit 4, and `clk_out_en` follows mode bit 1. `ovf_pulse` is high for one cycle after each rollover or down-count reload, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_mode | input | 1 | Tick divides by 6 instead of 12 |
| cnt_pin | input | 1 | External count input, falling edges counted |
| strobe_pin | input | 1 | External capture/reload strobe and up/down direction |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle rollover pulse |
| rx_clk_sel | output | 1 | Receive clock taken from this timer |
| tx_clk_sel | output | 1 | Transmit clock taken from this timer |
| clk_out_en | output | 1 | Clock output enable |

## Verification
The counter is driven by free internal ticks at both divide ratios over fixed windows, and by trains of external count pulses, with run on and run off. The same strobe edge is then applied under capture, reload, baud, disabled and up/down settings. Comparing the counter, the capture bytes and the flags after each edge separates a capture from a reload from an ignored edge. Rollovers are forced from preset values so the reload target, the wrap to zero and the down-count load of FFFFh can each be told apart. Writes that land in the exact cycle of a count step or a flag event show which side has priority.

// File: rtl/cr_timer16.sv
module cr_timer16 #(
  parameter int ADDR_W   = 3,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              cnt_pin,
  input  logic              strobe_pin,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              ovf_pulse,
  output logic              rx_clk_sel,
  output logic              tx_clk_sel,
  output logic              clk_out_en
);
  localparam int PRE_W = $clog2(SLOW_DIV);
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(SLOW_DIV - 1);
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(FAST_DIV - 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RLO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RHI  = ADDR_W'(5);

  logic [7:0]       ctrl;
  logic [1:0]       mode;
  logic [15:0]      cnt, cnt_nx, cap;
  logic [2:0]       cs, ss;
  logic [PRE_W-1:0] pre;

  wire tf      = ctrl[7];
  wire exf     = ctrl[6];
  wire rclk    = ctrl[5];
  wire tclk    = ctrl[4];
  wire exen    = ctrl[3];
  wire run     = ctrl[2];
  wire ext_sel = ctrl[1];
  wire cp      = ctrl[0];
  wire dcen    = mode[0];

  wire baud        = rclk | tclk;
  wire reload_mode = baud | ~cp;
  wire up_down     = dcen & ~cp & ~baud;
  wire cnt_fall    = cs[2] & ~cs[1];
  wire st_fall     = ss[2] & ~ss[1];
  wire count_up    = ~up_down | ss[1];

  wire [PRE_W-1:0] pre_last = fast_mode ? FAST_LAST : SLOW_LAST;
  wire tick    = (pre >= pre_last);
  wire step    = run & (ext_sel ? cnt_fall : tick);
  wire wrap_up = step & count_up & (cnt == 16'hFFFF);
  wire wrap_dn = step & ~count_up & (cnt == cap);
  wire wrap    = wrap_up | wrap_dn;

  wire ext_evt    = st_fall & exen & ~baud & ~up_down;
  wire capt       = ext_evt & cp;
  wire ext_reload = ext_evt & ~cp;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_clo  = bus_wr && bus_addr == A_CLO;
  wire wr_chi  = bus_wr && bus_addr == A_CHI;

  assign irq        = tf | (exf & ~dcen);
  assign rx_clk_sel = rclk;
  assign tx_clk_sel = tclk;
  assign clk_out_en = mode[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs  <= 3'b111;
      ss  <= 3'b111;
      pre <= '0;
    end else begin
      cs  <= {cs[1:0], cnt_pin};
      ss  <= {ss[1:0], strobe_pin};
      pre <= tick ? '0 : pre + 1'b1;
    end

  always_comb begin
    cnt_nx = cnt;
    if (wrap_dn)      cnt_nx = 16'hFFFF;
    else if (wrap_up) cnt_nx = reload_mode ? cap : 16'h0000;
    else if (step)    cnt_nx = count_up ? cnt + 16'd1 : cnt - 16'd1;
    if (ext_reload)   cnt_nx = cap;
    if (wr_clo)       cnt_nx = {cnt[15:8], bus_wdata};
    if (wr_chi)       cnt_nx = {bus_wdata, cnt[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl      <= 8'h00;
      mode      <= 2'b00;
      cnt       <= 16'h0000;
      cap       <= 16'h0000;
      ovf_pulse <= 1'b0;
    end else begin
      cnt       <= cnt_nx;
      ovf_pulse <= wrap;
      if (wr_ctrl) ctrl <= bus_wdata;
      else begin
        if (wrap && !baud)            ctrl[7] <= 1'b1;
        if (ext_evt)                  ctrl[6] <= 1'b1;
        else if (wrap && up_down)     ctrl[6] <= ~exf;
      end
      if (bus_wr && bus_addr == A_MODE) mode <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_RLO)  cap[7:0] <= bus_wdata;
      else if (capt)                    cap[7:0] <= cnt[7:0];
      if (bus_wr && bus_addr == A_RHI)  cap[15:8] <= bus_wdata;
      else if (capt)                    cap[15:8] <= cnt[15:8];
    end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_MODE:  bus_rdata = {6'b0, mode};
      A_CLO:   bus_rdata = cnt[7:0];
      A_CHI:   bus_rdata = cnt[15:8];
      A_RLO:   bus_rdata = cap[7:0];
      A_RHI:   bus_rdata = cap[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr && !(st_fall && exen)) |=> $stable(cnt)); // R3
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !(st_fall && exen)) |=> $stable(cap)); // R6
  AST_RELOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && $past(reload_mode && !up_down && !bus_wr)) |-> (cnt == cap)); // R5
  AST_NO_TF_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !wr_ctrl) |=> !$rose(ctrl[7])); // R7
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dcen && !tf) |-> !irq); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R11
endmodule

// File: tb/cr_timer16_test.sv
module cr_timer16_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fast_mode = 1'b0, cnt_pin = 1'b1, strobe_pin = 1'b1;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, ovf_pulse, rx_clk_sel, tx_clk_sel, clk_out_en;

  always #10 clk = ~clk;

  cr_timer16 uut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .cnt_pin(cnt_pin),
    .strobe_pin(strobe_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ovf_pulse(ovf_pulse), .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel),
    .clk_out_en(clk_out_en)
  );

  typedef struct { int sel; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      8:  return {7'b0, irq};
      9:  return {7'b0, ovf_pulse};
      10: return {7'b0, rx_clk_sel};
      11: return {7'b0, tx_clk_sel};
      12: return {7'b0, clk_out_en};
      default: return bus_rdata;
    endcase
  endfunction

  initial forever begin
    item_t it;
    wait (q.size() > 0);
    it = q.pop_front();
    total++;
    if (observe(it.sel) !== it.exp) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, observe(it.sel), it.exp);
    end
  end

  task automatic chk(int sel, logic [7:0] exp, string tag);
    item_t it;
    if (sel < 8) bus_addr = sel[2:0];
    #1;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pcnt();
    @(negedge clk); cnt_pin = 1'b0;
    repeat (2) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pstb();
    @(negedge clk); strobe_pin = 1'b0;
    repeat (2) @(negedge clk);
    strobe_pin = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rollover_pulse(string tag);
    cnt_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(9, 8'h01, tag);
    @(negedge clk);
    chk(9, 8'h00, tag);
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(0, 8'h00, "R1 ctrl"); chk(1, 8'h00, "R1 mode");
    chk(2, 8'h00, "R1 cnt lo"); chk(3, 8'h00, "R1 cnt hi");
    chk(4, 8'h00, "R1 cap lo"); chk(5, 8'h00, "R1 cap hi");
    chk(8, 8'h00, "R1 irq"); chk(9, 8'h00, "R1 ovf_pulse");
    chk(10, 8'h00, "R1 rx"); chk(11, 8'h00, "R1 tx"); chk(12, 8'h00, "R1 clk_out_en");
    // R2 mode width, R11 clock output enable
    wr(1, 8'hFF);
    chk(1, 8'h03, "R2 mode upper bits zero");
    chk(12, 8'h01, "R11 clk_out_en");
    wr(1, 8'h00);
    chk(6, 8'h00, "R2 unused address");
    // R3 internal tick, divide by 12 then by 6
    wr(0, 8'h04);
    repeat (118) @(negedge clk);
    wr(0, 8'h00);
    chk(2, 8'h0A, "R3 tick/12 lo"); chk(3, 8'h00, "R3 tick/12 hi");
    fast_mode = 1'b1;
    wr(2, 8'h00);
    wr(0, 8'h04);
    repeat (58) @(negedge clk);
    wr(0, 8'h00);
    chk(2, 8'h0A, "R3 tick/6");
    fast_mode = 1'b0;
    // R3 external count and stop
    wr(2, 8'h00);
    wr(0, 8'h06);
    for (int i = 0; i < 5; i++) pcnt();
    chk(2, 8'h05, "R3 external count");
    wr(0, 8'h02);
    for (int i = 0; i < 3; i++) pcnt();
    chk(2, 8'h05, "R3 stopped holds");
    // R4 capture
    wr(2, 8'h34); wr(3, 8'h12);
    wr(0, 8'h0B);
    pstb();
    chk(4, 8'h34, "R4 capture lo"); chk(5, 8'h12, "R4 capture hi");
    chk(0, 8'h4B, "R4 ext flag"); chk(8, 8'h01, "R9 irq from ext flag");
    wr(0, 8'h0B);
    chk(8, 8'h00, "R10 flag cleared by write");
    // R6 strobe ignored without enable
    wr(0, 8'h03); wr(2, 8'h55); wr(3, 8'h55);
    pstb();
    chk(4, 8'h34, "R6 cap lo kept"); chk(5, 8'h12, "R6 cap hi kept");
    chk(0, 8'h03, "R6 no flag"); chk(2, 8'h55, "R6 counter kept");
    // R4 wrap to zero in capture mode
    wr(0, 8'h07); wr(2, 8'hFF); wr(3, 8'hFF);
    rollover_pulse("R11 pulse capture wrap");
    chk(2, 8'h00, "R4 wrap lo"); chk(3, 8'h00, "R4 wrap hi");
    chk(0, 8'h87, "R4 ovf flag"); chk(8, 8'h01, "R9 irq from ovf");
    wr(0, 8'h00);
    // R5 reload on rollover and on strobe
    wr(4, 8'hF0); wr(5, 8'hFF); wr(2, 8'hFE); wr(3, 8'hFF);
    wr(0, 8'h06);
    pcnt(); pcnt();
    chk(2, 8'hF0, "R5 reload lo"); chk(3, 8'hFF, "R5 reload hi");
    chk(0, 8'h86, "R5 ovf flag");
    wr(0, 8'h0E); wr(2, 8'h10); wr(3, 8'h00);
    pstb();
    chk(2, 8'hF0, "R5 strobe reload lo"); chk(3, 8'hFF, "R5 strobe reload hi");
    chk(0, 8'h4E, "R5 ext flag");
    // R7 baud mode
    wr(0, 8'h27); wr(2, 8'hFF); wr(3, 8'hFF);
    rollover_pulse("R11 pulse baud");
    chk(2, 8'hF0, "R7 forced reload"); chk(0, 8'h27, "R7 no ovf flag");
    chk(10, 8'h01, "R11 rx select"); chk(11, 8'h00, "R11 tx select");
    wr(0, 8'h1F); wr(2, 8'h11); wr(3, 8'h11);
    pstb();
    chk(2, 8'h11, "R7 strobe no reload"); chk(4, 8'hF0, "R7 strobe no capture");
    chk(0, 8'h1F, "R7 strobe no flag"); chk(11, 8'h01, "R11 tx select");
    // R8 up/down
    wr(0, 8'h00); wr(1, 8'h01);
    wr(2, 8'hFF); wr(3, 8'hFF);
    wr(0, 8'h06);
    pcnt();
    chk(2, 8'hF0, "R8 up rollover"); chk(0, 8'hC6, "R8 flags up");
    chk(8, 8'h01, "R8 irq from ovf");
    wr(0, 8'h06);
    strobe_pin = 1'b0;
    repeat (4) @(negedge clk);
    wr(2, 8'hF1); wr(3, 8'hFF);
    pcnt();
    chk(2, 8'hF0, "R8 count down"); chk(0, 8'h06, "R8 no flag yet");
    pcnt();
    chk(2, 8'hFF, "R8 underflow lo"); chk(3, 8'hFF, "R8 underflow hi");
    chk(0, 8'hC6, "R8 flags down");
    wr(0, 8'h46);
    chk(8, 8'h00, "R9 ext flag masked"); chk(0, 8'h46, "R9 ext flag kept");
    strobe_pin = 1'b1;
    repeat (4) @(negedge clk);
    wr(1, 8'h00); wr(0, 8'h00);
    // R10 write priority over count and flag set
    wr(2, 8'h10); wr(3, 8'h00); wr(0, 8'h06);
    cnt_pin = 1'b0;
    @(negedge clk);
    wr(2, 8'h77);
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk(2, 8'h77, "R10 counter write wins"); chk(3, 8'h00, "R10 other byte kept");
    wr(2, 8'hFF); wr(3, 8'hFF);
    cnt_pin = 1'b0;
    @(negedge clk);
    wr(0, 8'h06);
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk(0, 8'h06, "R10 control write wins"); chk(2, 8'hF0, "R10 reload still done");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule